// File: doc/BRIEF.md
# Out-of-Order Issue Pool with Result Broadcast

This block accepts decoded integer instructions one at a time, in program order, and parks each one in a free station of the matching unit class (add/subtract, multiply/divide, load). At the moment of issue every source register is resolved. A register with no outstanding writer supplies its value directly. A register that is still awaited supplies the tag of the station that will produce it. A status table maps each architectural register to its most recent producing station. Because of this renaming, execution can proceed out of order and later writers never disturb earlier readers.

A station starts its fixed-latency countdown once both of its operands are present. At most one station per class starts in any cycle. Finished results compete for a single broadcast bus. Every cycle, each waiting station checks the bus tag against its own missing-operand tags, and the register file takes the value only when the register's status entry still names the broadcasting station. Execution units are modelled as counters that apply a plain integer operation. A register read port exposes the architectural file and its pending flags.

Top module: `rs_pool`

## Requirements
- R1: After reset all stations are free, no result is on the bus, no register is pending, and register r holds the value r.
- R2: An accepted instruction goes to the lowest-numbered free station of its class, and `in_tag` reports that station. Stations 0-2 are add/subtract, 3-4 multiply/divide and 5-7 load.
- R3: The operation codes are 0 add, 1 subtract, 2 multiply (low 16 bits), 3 divide (an all-ones result for a zero divisor) and 4 load (result is the sum of the two operands). Suppose an instruction with both operands available is accepted at clock edge E. Its result is then on the bus in the cycle that begins L edges after E, where L is 2 for add, subtract and load, 10 for multiply and 40 for divide.
- R4: A station whose operand is awaited takes the value from the bus in the cycle that the producing tag is broadcast, and starts execution only in the following cycle. For a 2-cycle consumer, its result is broadcast 3 cycles after its producer's broadcast.
- R5: While every station of an instruction's class is busy, `in_ready` is low for that class, and it stays high for a class that still has a free station.
- R6: The register file is written by a broadcast only when the register's status entry names the broadcasting station, so the youngest writer in program order always determines the final register value.
- R7: When several stations finish in the same cycle, the lowest-numbered station is granted the bus. The others keep their results and retry in the next cycle.
- R8: An instruction accepted in the same cycle as the broadcast of one of its source tags takes the broadcast value rather than recording the tag.
- R9: A station is freed at the end of its broadcast cycle and can be allocated again from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_op | input | 3 | Operation code |
| in_dst | input | 3 | Destination register |
| in_srcj | input | 3 | First source register |
| in_srck | input | 3 | Second source register |
| in_ready | output | 1 | A station of the offered class is free |
| in_tag | output | 3 | Station that takes the offered instruction |
| bus_valid | output | 1 | A result is broadcast this cycle |
| bus_tag | output | 3 | Station whose result is broadcast |
| bus_value | output | 16 | Broadcast result |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Architectural register value |
| rd_busy | output | 1 | The register awaits a producer |

## Verification
An independent operation accepted at edge E broadcasts in the cycle that begins L edges later, where L is 2, 10 or 40. A woken consumer broadcasts 3 cycles after its producer. A consumer accepted during its producer's broadcast cycle also broadcasts 3 cycles after that broadcast. A station's class becomes ready again one cycle after the station broadcasts. The bench numbers every clock edge and records the edge at which each tag is accepted and the cycle in which it appears on the bus. It samples on falling edges and compares these recorded numbers against the spacings above. Every broadcast value is compared with the result that the program-order model predicts for that tag.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_DIV  = 3'd3,
        OP_LOAD = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        CL_ADD = 2'd0,
        CL_MUL = 2'd1,
        CL_LD  = 2'd2
    } cls_e;

    localparam int NUM_CLS = 3;

    function automatic cls_e op_class(input logic [2:0] op);
        case (op)
            OP_MUL, OP_DIV: return CL_MUL;
            OP_LOAD:        return CL_LD;
            default:        return CL_ADD;
        endcase
    endfunction

endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N = 8,
    parameter int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);
    // lowest set request wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_alu.sv
module rs_alu
    import rs_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    always_comb begin
        case (op_e'(op))
            OP_SUB:  y = a - b;
            OP_MUL:  y = a * b;
            OP_DIV:  y = (b == '0) ? '1 : a / b;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/rs_pool.sv
module rs_pool
    import rs_pkg::*;
#(
    parameter int N_ADD   = 3,
    parameter int N_MUL   = 2,
    parameter int N_LD    = 3,
    parameter int N_REG   = 8,
    parameter int DW      = 16,
    parameter int LAT_ADD = 2,
    parameter int LAT_MUL = 10,
    parameter int LAT_DIV = 40,
    parameter int LAT_LD  = 2,
    localparam int NS     = N_ADD + N_MUL + N_LD,
    localparam int TW     = $clog2(NS),
    localparam int RW     = $clog2(N_REG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    in_op,
    input  logic [RW-1:0] in_dst,
    input  logic [RW-1:0] in_srcj,
    input  logic [RW-1:0] in_srck,
    output logic          in_ready,
    output logic [TW-1:0] in_tag,
    output logic          bus_valid,
    output logic [TW-1:0] bus_tag,
    output logic [DW-1:0] bus_value,
    input  logic [RW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_busy
);
    localparam int LAT_A   = (LAT_ADD > LAT_LD) ? LAT_ADD : LAT_LD;
    localparam int LAT_B   = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
    localparam int LAT_MAX = (LAT_A > LAT_B) ? LAT_A : LAT_B;
    localparam int CW      = (LAT_MAX > 2) ? $clog2(LAT_MAX) : 1;

    typedef struct packed {
        logic          busy;
        logic          exec;
        logic [2:0]    op;
        logic          jw;      // first operand awaited
        logic [TW-1:0] jt;
        logic [DW-1:0] jv;
        logic          kw;      // second operand awaited
        logic [TW-1:0] kt;
        logic [DW-1:0] kv;
        logic [CW-1:0] cnt;
        logic [DW-1:0] res;
    } ent_t;

    typedef struct packed {
        ent_t [NS-1:0]               ent;
        logic [N_REG-1:0]            sv;   // register has a pending producer
        logic [N_REG-1:0][TW-1:0]    st;   // producing station
        logic [N_REG-1:0][DW-1:0]    rf;
    } state_t;

    function automatic logic [NS-1:0] cls_mask(input int c);
        int lo, hi;
        logic [NS-1:0] m;
        lo = (c == 0) ? 0 : (c == 1) ? N_ADD : N_ADD + N_MUL;
        hi = (c == 0) ? N_ADD : (c == 1) ? N_ADD + N_MUL : NS;
        for (int i = 0; i < NS; i++) m[i] = (i >= lo) && (i < hi);
        return m;
    endfunction

    function automatic int op_lat(input logic [2:0] op);
        case (op_e'(op))
            OP_MUL:  return LAT_MUL;
            OP_DIV:  return LAT_DIV;
            OP_LOAD: return LAT_LD;
            default: return LAT_ADD;
        endcase
    endfunction

    state_t q, d;

    logic [NS-1:0] busy_vec, exec_vec, wait_vec, rdy_vec, done_vec, disp_vec;
    logic [NS-1:0][DW-1:0] alu_y;
    logic [NUM_CLS-1:0]         free_v, disp_v;
    logic [NUM_CLS-1:0][TW-1:0] free_i, disp_i;
    cls_e in_cls;

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            busy_vec[s] = q.ent[s].busy;
            exec_vec[s] = q.ent[s].exec;
            wait_vec[s] = q.ent[s].jw | q.ent[s].kw;
            rdy_vec[s]  = q.ent[s].busy & ~q.ent[s].exec & ~wait_vec[s];
            done_vec[s] = q.ent[s].exec & (q.ent[s].cnt == '0);
        end
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        localparam logic [NS-1:0] MASK = cls_mask(c);
        rs_pick #(.N(NS), .W(TW)) u_free (
            .req(~busy_vec & MASK), .found(free_v[c]), .idx(free_i[c]));
        rs_pick #(.N(NS), .W(TW)) u_disp (
            .req(rdy_vec & MASK), .found(disp_v[c]), .idx(disp_i[c]));
    end

    rs_pick #(.N(NS), .W(TW)) u_bus (
        .req(done_vec), .found(bus_valid), .idx(bus_tag));

    for (genvar s = 0; s < NS; s++) begin : g_alu
        rs_alu #(.DW(DW)) u_alu (
            .op(q.ent[s].op), .a(q.ent[s].jv), .b(q.ent[s].kv), .y(alu_y[s]));
    end

    always_comb begin
        disp_vec = '0;
        for (int c = 0; c < NUM_CLS; c++)
            if (disp_v[c]) disp_vec[disp_i[c]] = 1'b1;
    end

    assign in_cls    = op_class(in_op);
    assign in_ready  = free_v[in_cls];
    assign in_tag    = free_i[in_cls];
    assign bus_value = q.ent[bus_tag].res;
    assign rd_data   = q.rf[rd_addr];
    assign rd_busy   = q.sv[rd_addr];

    always_comb begin
        d = q;
        // stations: release, countdown, wakeup, start
        for (int s = 0; s < NS; s++) begin
            if (bus_valid && bus_tag == TW'(s)) begin
                d.ent[s].busy = 1'b0;
                d.ent[s].exec = 1'b0;
            end else if (q.ent[s].exec && q.ent[s].cnt != '0) begin
                d.ent[s].cnt = q.ent[s].cnt - 1'b1;
            end
            if (bus_valid && q.ent[s].busy && q.ent[s].jw && q.ent[s].jt == bus_tag) begin
                d.ent[s].jw = 1'b0;
                d.ent[s].jv = bus_value;
            end
            if (bus_valid && q.ent[s].busy && q.ent[s].kw && q.ent[s].kt == bus_tag) begin
                d.ent[s].kw = 1'b0;
                d.ent[s].kv = bus_value;
            end
            if (disp_vec[s]) begin
                d.ent[s].exec = 1'b1;
                d.ent[s].cnt  = CW'(op_lat(q.ent[s].op) - 1);
                d.ent[s].res  = alu_y[s];
            end
        end
        // register file: only the named producer may write
        for (int r = 0; r < N_REG; r++) begin
            if (bus_valid && q.sv[r] && q.st[r] == bus_tag) begin
                d.rf[r] = bus_value;
                d.sv[r] = 1'b0;
            end
        end
        // issue with operand resolution and same-cycle bypass
        if (in_valid && in_ready) begin
            d.ent[in_tag].busy = 1'b1;
            d.ent[in_tag].exec = 1'b0;
            d.ent[in_tag].op   = in_op;
            d.ent[in_tag].cnt  = '0;
            d.ent[in_tag].res  = '0;
            d.ent[in_tag].jt   = q.st[in_srcj];
            d.ent[in_tag].kt   = q.st[in_srck];
            if (!q.sv[in_srcj]) begin
                d.ent[in_tag].jw = 1'b0;
                d.ent[in_tag].jv = q.rf[in_srcj];
            end else if (bus_valid && bus_tag == q.st[in_srcj]) begin
                d.ent[in_tag].jw = 1'b0;
                d.ent[in_tag].jv = bus_value;
            end else begin
                d.ent[in_tag].jw = 1'b1;
                d.ent[in_tag].jv = '0;
            end
            if (!q.sv[in_srck]) begin
                d.ent[in_tag].kw = 1'b0;
                d.ent[in_tag].kv = q.rf[in_srck];
            end else if (bus_valid && bus_tag == q.st[in_srck]) begin
                d.ent[in_tag].kw = 1'b0;
                d.ent[in_tag].kv = bus_value;
            end else begin
                d.ent[in_tag].kw = 1'b1;
                d.ent[in_tag].kv = '0;
            end
            d.sv[in_dst] = 1'b1;
            d.st[in_dst] = in_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ent <= '0;
            q.sv  <= '0;
            q.st  <= '0;
            for (int r = 0; r < N_REG; r++) q.rf[r] <= DW'(r);
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
    parameter int NS = 8,
    parameter int TW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic [TW-1:0] in_tag,
    input logic          bus_valid,
    input logic [TW-1:0] bus_tag,
    input logic [NS-1:0] busy_vec,
    input logic [NS-1:0] exec_vec,
    input logic [NS-1:0] wait_vec,
    input logic [NS-1:0] done_vec
);
    // R2
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> !busy_vec[in_tag]);

    // R2
    alloc_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy_vec[$past(in_tag)]);

    // R7
    bus_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (busy_vec[bus_tag] && exec_vec[bus_tag]));

    // R7
    loser_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(done_vec) > 1) |=> bus_valid);

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> !busy_vec[$past(bus_tag)]);

    for (genvar s = 0; s < NS; s++) begin : g_st
        // R4
        start_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(exec_vec[s]) |-> $past(busy_vec[s] && !wait_vec[s]));
    end
endmodule

bind rs_pool rs_pool_chk #(.NS(NS), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .bus_valid(bus_valid), .bus_tag(bus_tag),
    .busy_vec(busy_vec), .exec_vec(exec_vec), .wait_vec(wait_vec),
    .done_vec(done_vec));

// File: tb/tb_rs_pool.sv
module tb_rs_pool;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = 3'd0, in_dst = 3'd0, in_srcj = 3'd0, in_srck = 3'd0;
    logic        in_ready;
    logic [2:0]  in_tag;
    logic        bus_valid;
    logic [2:0]  bus_tag;
    logic [15:0] bus_value;
    logic [2:0]  rd_addr = 3'd0;
    logic [15:0] rd_data;
    logic        rd_busy;

    rs_pool dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_srcj(in_srcj), .in_srck(in_srck),
        .in_ready(in_ready), .in_tag(in_tag), .bus_valid(bus_valid),
        .bus_tag(bus_tag), .bus_value(bus_value), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_busy(rd_busy));

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int arch[8];
    int exp_v[8], iss_cyc[8], bus_cyc[8], bus_val[8];
    bit pend[8];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, expv);
        end
    endtask

    function automatic int model_op(input int op, input int a, input int b);
        case (op)
            1: return (a - b) & 16'hFFFF;
            2: return (a * b) & 16'hFFFF;
            3: return (b == 0) ? 16'hFFFF : a / b;
            default: return (a + b) & 16'hFFFF;
        endcase
    endfunction

    // per-clock comparison of the broadcast bus with the reference
    always @(negedge clk) begin
        if (rst_n && bus_valid) begin
            int t;
            t = int'(bus_tag);
            chk(pend[t], "R4 broadcast tag outstanding", int'(pend[t]), 1);
            chk(int'(bus_value) == exp_v[t], "R3 broadcast value", int'(bus_value), exp_v[t]);
            pend[t] = 1'b0;
            bus_cyc[t] = cyc;
            bus_val[t] = int'(bus_value);
        end
    end

    task automatic issue(input int op, input int dst, input int sj, input int sk, output int tag);
        @(negedge clk);
        in_op = 3'(op); in_dst = 3'(dst); in_srcj = 3'(sj); in_srck = 3'(sk);
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        tag = int'(in_tag);
        exp_v[tag] = model_op(op, arch[sj], arch[sk]);
        arch[dst] = exp_v[tag];
        pend[tag] = 1'b1;
        iss_cyc[tag] = cyc;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain();
        bit any;
        do begin
            @(negedge clk);
            #2;
            any = 1'b0;
            for (int i = 0; i < 8; i++) any |= pend[i];
        end while (any);
    endtask

    task automatic wait_bus(input int t);
        do begin
            @(negedge clk);
            #2;
        end while (!(bus_valid && int'(bus_tag) == t));
    endtask

    task automatic read_reg(input int r, output int v, output bit b);
        rd_addr = 3'(r);
        #1;
        v = int'(rd_data);
        b = rd_busy;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int ta, tb, tc, tm, v;
        bit b;
        int unsigned seed;
        for (int i = 0; i < 8; i++) begin
            arch[i] = i;
            pend[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk(!bus_valid, "R1 bus idle", int'(bus_valid), 0);
        chk(in_ready, "R1 add station free", int'(in_ready), 1);
        for (int r = 0; r < 8; r++) begin
            read_reg(r, v, b);
            chk(v == r && !b, "R1 register reset", v, r);
        end

        // R2 R3 add latency and allocation
        issue(0, 1, 2, 3, ta);
        chk(ta == 0, "R2 lowest add station", ta, 0);
        drain();
        chk(bus_cyc[ta] - iss_cyc[ta] - 1 == 2, "R3 add latency", bus_cyc[ta] - iss_cyc[ta] - 1, 2);
        issue(1, 4, 3, 5, ta);
        drain();
        chk(bus_val[ta] == 16'hFFFE, "R3 subtract wraps", bus_val[ta], 16'hFFFE);

        // R3 multiply, divide, divide by zero
        issue(2, 5, 2, 3, tm);
        chk(tm == 3, "R2 lowest mul station", tm, 3);
        issue(3, 6, 7, 2, tb);
        chk(tb == 4, "R2 second mul station", tb, 4);
        drain();
        chk(bus_cyc[tm] - iss_cyc[tm] - 1 == 10, "R3 multiply latency", bus_cyc[tm] - iss_cyc[tm] - 1, 10);
        chk(bus_cyc[tb] - iss_cyc[tb] - 1 == 40, "R3 divide latency", bus_cyc[tb] - iss_cyc[tb] - 1, 40);
        issue(3, 7, 1, 0, tb);
        drain();
        chk(bus_val[tb] == 16'hFFFF, "R3 divide by zero", bus_val[tb], 16'hFFFF);
        issue(4, 2, 3, 4, tc);
        chk(tc == 5, "R2 lowest load station", tc, 5);
        drain();
        chk(bus_cyc[tc] - iss_cyc[tc] - 1 == 2, "R3 load latency", bus_cyc[tc] - iss_cyc[tc] - 1, 2);

        // R4 dependent wakeup
        issue(2, 1, 2, 3, tm);
        issue(0, 2, 1, 1, ta);
        drain();
        chk(bus_cyc[ta] == bus_cyc[tm] + 3, "R4 consumer after wakeup", bus_cyc[ta], bus_cyc[tm] + 3);

        // R8 same-cycle bypass
        issue(0, 3, 0, 1, ta);
        repeat (2) @(posedge clk);
        issue(0, 5, 3, 3, tb);
        drain();
        chk(iss_cyc[tb] == bus_cyc[ta], "R8 issued in broadcast cycle", iss_cyc[tb], bus_cyc[ta]);
        chk(bus_cyc[tb] == bus_cyc[ta] + 3, "R8 bypass timing", bus_cyc[tb], bus_cyc[ta] + 3);

        // R6 youngest writer wins
        issue(3, 4, 7, 2, tm);
        issue(0, 5, 4, 1, ta);
        issue(0, 4, 0, 1, tb);
        wait_bus(tb);
        @(negedge clk);
        read_reg(4, v, b);
        chk(v == arch[4] && !b, "R6 younger writer updates", v, arch[4]);
        read_reg(5, v, b);
        chk(b, "R6 reader still pending", int'(b), 1);
        drain();
        @(negedge clk);
        read_reg(4, v, b);
        chk(v == arch[4], "R6 older writer ignored", v, arch[4]);

        // R5 R9 stall and release
        issue(2, 1, 3, 3, tm);
        issue(0, 2, 1, 0, ta);
        issue(0, 3, 1, 1, ta);
        issue(0, 6, 1, 0, ta);
        @(negedge clk);
        in_op = 3'd0;
        #1;
        chk(!in_ready, "R5 add class full", int'(in_ready), 0);
        in_op = 3'd4;
        #1;
        chk(in_ready, "R5 load class still free", int'(in_ready), 1);
        in_op = 3'd0;
        do begin
            @(negedge clk);
            #2;
        end while (!(bus_valid && bus_tag < 3'd3));
        chk(!in_ready, "R9 not free during broadcast", int'(in_ready), 0);
        @(negedge clk);
        #1;
        chk(in_ready, "R9 free after broadcast", int'(in_ready), 1);
        drain();

        // R7 bus priority
        issue(2, 1, 2, 2, tm);
        issue(0, 3, 1, 0, ta);
        issue(4, 4, 1, 2, tc);
        drain();
        chk(bus_cyc[ta] == bus_cyc[tm] + 3, "R7 winner timing", bus_cyc[ta], bus_cyc[tm] + 3);
        chk(bus_cyc[tc] == bus_cyc[ta] + 1, "R7 loser retries next cycle", bus_cyc[tc], bus_cyc[ta] + 1);

        // mixed stream, values checked on every broadcast
        seed = 32'h2468ACE1;
        for (int n = 0; n < 60; n++) begin
            int op, sel, t;
            seed = seed * 32'd1103515245 + 32'd12345;
            sel = int'((seed >> 16) & 32'h7);
            case (sel)
                0, 1, 2: op = 0;
                3:       op = 1;
                4, 5:    op = 4;
                6:       op = 2;
                default: op = (((seed >> 20) & 32'h3) == 0) ? 3 : 2;
            endcase
            issue(op, int'((seed >> 8) & 32'h7), int'((seed >> 11) & 32'h7),
                  int'((seed >> 24) & 32'h7), t);
        end
        drain();
        @(negedge clk);
        for (int r = 0; r < 8; r++) begin
            read_reg(r, v, b);
            chk(v == arch[r] && !b, "R6 final register", v, arch[r]);
        end
        finish_run();
    end
endmodule